// File: doc/BRIEF.md
# Parallel DAC Bus Sequencer

A clocked controller that sits on the host side of a 16-bit parallel digital-to-analog converter with a double-buffered input. The host hands it one command at a time (write a word, write a word and then load it, load only, read the input register back, or force the converter to its mid-scale or min-scale reset code). The sequencer turns each command into a waveform on the converter's control pins. These pins are chip select, the read/write line, the load strobe, the reset strobe, the reset-code select and a data bus that the host can drive or release.

Every minimum setup, hold and pulse width is given in nanoseconds. Each is turned into a cycle count by rounding up against a clock-period parameter. A read samples the bus only once the access time has passed. After chip select rises, the sequencer stays busy until the converter has released the bus. One command runs at a time. A request made while the sequencer is busy is dropped.

Top module: `dac_bus_seq`

## Requirements
- R1: While reset is asserted and afterwards until a command is accepted: chip select high, read/write high, load high, converter reset high, reset select 0, bus driver off, busy 0, done 0, read data 0.
- R2: Command codes on req_cmd are 0 write, 1 write then load, 2 load only, 3 read, 4 reset to mid-scale, 5 reset to min-scale. A code is taken at a rising clock edge where req_valid is 1 and busy is 0. Codes 6 and 7 are dropped with no pin activity and no busy.
- R3: For a write, the read/write line is low and the data is driven for ceil(10 ns/period) cycles before chip select falls. Chip select then stays low for ceil(25 ns/period) cycles. Read/write stays low and the data stays driven for ceil(10 ns/period) cycles after chip select rises.
- R4: The load strobe is low for ceil(20 ns/period) cycles while chip select is high. For code 1 it follows directly after the write hold cycles.
- R5: For a read, the read/write line is high for ceil(10 ns/period) cycles before chip select falls, and chip select then stays low for ceil(90 ns/period) cycles. The bus is not driven.
- R6: The read data is sampled from the bus at the first clock edge that lies at least 70 ns after chip select fell. rd_data changes only then.
- R7: After a read, busy stays high for max(ceil(10 ns/period), ceil(100 ns/period)) cycles after chip select rises.
- R8: A reset command holds the converter reset low for ceil(30 ns/period) cycles. Reset select is 1 for mid-scale and 0 for min-scale. Reset select is held for ceil(10 ns/period) cycles after the reset rises and keeps its value until the next reset command.
- R9: Busy is high from the cycle after acceptance through the last hold cycle of the sequence. Requests made while busy are ignored.
- R10: Done is a one-cycle pulse in the first idle cycle after each accepted command, with busy low.
- R11: The bus driver is enabled only in the setup, strobe and hold cycles of a write.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| req_valid | input | 1 | Command request |
| req_cmd | input | 3 | Command code (R2) |
| req_data | input | 16 | Word to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read back |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_rw | output | 1 | 1 = read, 0 = write |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_rst_n | output | 1 | Converter reset strobe, active low |
| dac_rst_mid | output | 1 | Reset select, 1 = mid-scale, 0 = min-scale |
| dac_bus_out | output | 16 | Data driven to the bus |
| dac_bus_oe | output | 1 | Bus driver enable |
| dac_bus_in | input | 16 | Data read from the bus |

## Verification
The bench goes after the edges of each phase. A setup or hold one cycle short would show up as a read/write or chip select transition one cycle early when compared against the per-cycle model. A read that samples before the access time would latch the garbage pattern the bench's converter model puts on the bus until 70 ns after chip select falls. The bench also checks that a read lets the next command start only after the long bus-release wait. It checks that requests made while busy and unknown codes leave no trace on the pins. It checks that reset select never moves while the reset strobe is low or being held.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the parallel DAC bus sequencer.
// Assumes nothing beyond integer nanosecond timing parameters.
package dac_seq_pkg;

    // Host command codes; the numeric values are part of the interface.
    typedef enum logic [2:0] {
        CMD_WRITE      = 3'd0,
        CMD_WRITE_LOAD = 3'd1,
        CMD_LOAD       = 3'd2,
        CMD_READ       = 3'd3,
        CMD_RST_MID    = 3'd4,
        CMD_RST_MIN    = 3'd5
    } cmd_e;

    // Sequencer phases; each holds one fixed pin pattern for a counted time.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_W_SU,
        PH_W_STB,
        PH_W_HLD,
        PH_LOAD,
        PH_R_SU,
        PH_R_STB,
        PH_R_HLD,
        PH_X_RST,
        PH_X_HLD
    } phase_e;

    // Control pin pattern of one phase.
    typedef struct packed {
        logic cs_n;
        logic rw;
        logic ld_n;
        logic rst_n;
        logic oe;
    } pins_t;

    // Round a nanosecond time up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic cmd_known(logic [2:0] code);
        return code <= 3'd5;
    endfunction

    // Pin pattern driven during a phase.
    function automatic pins_t phase_pins(phase_e ph);
        pins_t p;
        p = '{cs_n: 1'b1, rw: 1'b1, ld_n: 1'b1, rst_n: 1'b1, oe: 1'b0};
        case (ph)
            PH_W_SU, PH_W_HLD: begin p.rw = 1'b0; p.oe = 1'b1; end
            PH_W_STB:          begin p.rw = 1'b0; p.oe = 1'b1; p.cs_n = 1'b0; end
            PH_LOAD:           p.ld_n = 1'b0;
            PH_R_STB:          p.cs_n = 1'b0;
            PH_X_RST:          p.rst_n = 1'b0;
            default:           ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
`timescale 1ns/1ps
// Phase down-counter. Loaded with (length-1) on entry to a phase; reports
// expiry when it reaches zero. Assumes the loader never loads during reset.
module dac_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
    assign count   = cnt_q;
endmodule

// File: rtl/dac_seq_ctrl.sv
`timescale 1ns/1ps
// Command acceptance and phase sequencing. Produces the next phase so the pin
// stage can register its pattern in step with the phase register. Assumes all
// phase lengths are at least one cycle and the access time fits the strobe.
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 5,
    parameter int W_SU_LEN  = 3,
    parameter int W_STB_LEN = 7,
    parameter int W_HLD_LEN = 3,
    parameter int LOAD_LEN  = 5,
    parameter int R_SU_LEN  = 3,
    parameter int R_STB_LEN = 23,
    parameter int R_HLD_LEN = 25,
    parameter int X_RST_LEN = 8,
    parameter int X_HLD_LEN = 3,
    parameter int ACC_CYC   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [DATA_W-1:0] req_data,
    input  logic              expired,
    input  logic [CNT_W-1:0]  count,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output phase_e            ph_d,
    output logic              sel_d,
    output logic [DATA_W-1:0] data_q,
    output logic              sample,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(R_STB_LEN - ACC_CYC);

    phase_e ph_q;
    logic   accept;
    logic   chain_q;
    logic   sel_q;
    logic   done_q;
    int unsigned len;

    // Next-phase decision: accept in idle, advance when the timer expires.
    always_comb begin
        ph_d   = ph_q;
        accept = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid && cmd_known(req_cmd)) begin
                    accept = 1'b1;
                    case (req_cmd)
                        CMD_WRITE, CMD_WRITE_LOAD: ph_d = PH_W_SU;
                        CMD_LOAD:                  ph_d = PH_LOAD;
                        CMD_READ:                  ph_d = PH_R_SU;
                        default:                   ph_d = PH_X_RST;
                    endcase
                end
            end
            PH_W_SU:  if (expired) ph_d = PH_W_STB;
            PH_W_STB: if (expired) ph_d = PH_W_HLD;
            PH_W_HLD: if (expired) ph_d = chain_q ? PH_LOAD : PH_IDLE;
            PH_LOAD:  if (expired) ph_d = PH_IDLE;
            PH_R_SU:  if (expired) ph_d = PH_R_STB;
            PH_R_STB: if (expired) ph_d = PH_R_HLD;
            PH_R_HLD: if (expired) ph_d = PH_IDLE;
            PH_X_RST: if (expired) ph_d = PH_X_HLD;
            PH_X_HLD: if (expired) ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    // Length of the phase about to be entered, for the timer load.
    always_comb begin
        case (ph_d)
            PH_W_SU:  len = W_SU_LEN;
            PH_W_STB: len = W_STB_LEN;
            PH_W_HLD: len = W_HLD_LEN;
            PH_LOAD:  len = LOAD_LEN;
            PH_R_SU:  len = R_SU_LEN;
            PH_R_STB: len = R_STB_LEN;
            PH_R_HLD: len = R_HLD_LEN;
            PH_X_RST: len = X_RST_LEN;
            PH_X_HLD: len = X_HLD_LEN;
            default:  len = 1;
        endcase
        load_val = CNT_W'(len - 1);
    end

    assign load   = (ph_d != ph_q) && (ph_d != PH_IDLE);
    assign sel_d  = accept ? (req_cmd == CMD_RST_MID) : sel_q;
    assign sample = (ph_q == PH_R_STB) && (count == SAMPLE_AT);
    assign busy   = (ph_q != PH_IDLE);
    assign done   = done_q;

    // Phase register, command attributes latched at acceptance, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            chain_q <= 1'b0;
            sel_q   <= 1'b0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            done_q <= (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
            if (accept) begin
                chain_q <= (req_cmd == CMD_WRITE_LOAD);
                sel_q   <= (req_cmd == CMD_RST_MID);
                if (req_cmd == CMD_WRITE || req_cmd == CMD_WRITE_LOAD)
                    data_q <= req_data;
            end
        end
    end
endmodule

// File: rtl/dac_seq_pins.sv
`timescale 1ns/1ps
// Pin register stage. Registers the pattern of the next phase so every pin
// changes on a clock edge with no decode glitches, holds the reset select
// between resets and captures read data on the sample strobe.
module dac_seq_pins
    import dac_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            ph_d,
    input  logic              sel_d,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic              cs_n,
    output logic              rw,
    output logic              ld_n,
    output logic              dac_rst_n,
    output logic              rst_mid,
    output logic              oe,
    output logic [DATA_W-1:0] rd_data
);
    pins_t pins_q;

    // Registered pin pattern, reset select and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q  <= '{cs_n: 1'b1, rw: 1'b1, ld_n: 1'b1, rst_n: 1'b1, oe: 1'b0};
            rst_mid <= 1'b0;
            rd_data <= '0;
        end else begin
            pins_q <= phase_pins(ph_d);
            if (ph_d == PH_X_RST) rst_mid <= sel_d;
            if (sample)           rd_data <= bus_in;
        end
    end

    assign cs_n      = pins_q.cs_n;
    assign rw        = pins_q.rw;
    assign ld_n      = pins_q.ld_n;
    assign dac_rst_n = pins_q.rst_n;
    assign oe        = pins_q.oe;
endmodule

// File: rtl/dac_bus_seq.sv
`timescale 1ns/1ps
// Host-side sequencer for a double-buffered parallel DAC. Converts one
// command at a time into chip select, read/write, load, reset and bus
// waveforms whose phase lengths are nanosecond minimums rounded up to clock
// cycles. Assumes the converter's bus input is valid by the access time.
module dac_bus_seq
    import dac_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 4,
    parameter int DATA_W         = 16,
    parameter int T_RW_SETUP_NS  = 10,
    parameter int T_RW_HOLD_NS   = 10,
    parameter int T_WR_CS_NS     = 25,
    parameter int T_LOAD_NS      = 20,
    parameter int T_RD_CS_NS     = 90,
    parameter int T_ACCESS_NS    = 70,
    parameter int T_RELEASE_NS   = 100,
    parameter int T_RST_NS       = 30,
    parameter int T_SEL_HOLD_NS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              dac_cs_n,
    output logic              dac_rw,
    output logic              dac_ld_n,
    output logic              dac_rst_n,
    output logic              dac_rst_mid,
    output logic [DATA_W-1:0] dac_bus_out,
    output logic              dac_bus_oe,
    input  logic [DATA_W-1:0] dac_bus_in
);
    localparam int SU_CYC     = ns_to_cyc(T_RW_SETUP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC   = ns_to_cyc(T_RW_HOLD_NS, CLK_PERIOD_NS);
    localparam int WCS_CYC    = ns_to_cyc(T_WR_CS_NS, CLK_PERIOD_NS);
    localparam int LOAD_CYC   = ns_to_cyc(T_LOAD_NS, CLK_PERIOD_NS);
    localparam int RCS_CYC    = ns_to_cyc(T_RD_CS_NS, CLK_PERIOD_NS);
    localparam int ACC_CYC    = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int REL_CYC    = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int RST_CYC    = ns_to_cyc(T_RST_NS, CLK_PERIOD_NS);
    localparam int SELH_CYC   = ns_to_cyc(T_SEL_HOLD_NS, CLK_PERIOD_NS);
    localparam int R_STB_LEN  = umax(RCS_CYC, ACC_CYC);
    localparam int R_HLD_LEN  = umax(HOLD_CYC, REL_CYC);
    localparam int MAX_LEN    = umax(umax(umax(R_STB_LEN, R_HLD_LEN), umax(WCS_CYC, LOAD_CYC)),
                                     umax(umax(SU_CYC, HOLD_CYC), umax(RST_CYC, SELH_CYC)));
    localparam int CNT_W      = $clog2(MAX_LEN + 1);

    phase_e           ph_d;
    logic             sel_d;
    logic             sample;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_count;
    logic [DATA_W-1:0] data_q;

    dac_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired),
        .count    (tmr_count)
    );

    dac_seq_ctrl #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .W_SU_LEN  (SU_CYC),
        .W_STB_LEN (WCS_CYC),
        .W_HLD_LEN (HOLD_CYC),
        .LOAD_LEN  (LOAD_CYC),
        .R_SU_LEN  (SU_CYC),
        .R_STB_LEN (R_STB_LEN),
        .R_HLD_LEN (R_HLD_LEN),
        .X_RST_LEN (RST_CYC),
        .X_HLD_LEN (SELH_CYC),
        .ACC_CYC   (ACC_CYC)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_data  (req_data),
        .expired   (tmr_expired),
        .count     (tmr_count),
        .load      (tmr_load),
        .load_val  (tmr_val),
        .ph_d      (ph_d),
        .sel_d     (sel_d),
        .data_q    (data_q),
        .sample    (sample),
        .busy      (busy),
        .done      (done)
    );

    dac_seq_pins #(.DATA_W(DATA_W)) i_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_d      (ph_d),
        .sel_d     (sel_d),
        .sample    (sample),
        .bus_in    (dac_bus_in),
        .cs_n      (dac_cs_n),
        .rw        (dac_rw),
        .ld_n      (dac_ld_n),
        .dac_rst_n (dac_rst_n),
        .rst_mid   (dac_rst_mid),
        .oe        (dac_bus_oe),
        .rd_data   (rd_data)
    );

    assign dac_bus_out = data_q;
endmodule

// File: rtl/dac_bus_seq_chk.sv
`timescale 1ns/1ps
// Timing checker for the sequencer pins. Measures pulse widths, setup and
// hold with its own counters and checks them against the cycle minimums.
module dac_bus_seq_chk #(
    parameter int SU_CYC   = 3,
    parameter int HOLD_CYC = 3,
    parameter int WCS_CYC  = 7,
    parameter int RCS_CYC  = 23,
    parameter int LOAD_CYC = 5,
    parameter int RST_CYC  = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rw,
    input logic ld_n,
    input logic dac_rst_n,
    input logic rst_mid,
    input logic oe,
    input logic busy,
    input logic done
);
    logic [15:0] cs_low, ld_low, rst_low, rw_age, hi_age;
    logic        rw_prev;

    // Width and age counters, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_low  <= '0;
            ld_low  <= '0;
            rst_low <= '0;
            rw_age  <= '0;
            hi_age  <= '1;
            rw_prev <= 1'b1;
        end else begin
            cs_low  <= cs_n      ? '0 : ((cs_low  == '1) ? cs_low  : cs_low  + 1'b1);
            ld_low  <= ld_n      ? '0 : ((ld_low  == '1) ? ld_low  : ld_low  + 1'b1);
            rst_low <= dac_rst_n ? '0 : ((rst_low == '1) ? rst_low : rst_low + 1'b1);
            hi_age  <= !cs_n     ? '0 : ((hi_age  == '1) ? hi_age  : hi_age  + 1'b1);
            rw_age  <= (rw != rw_prev) ? 16'd1 : ((rw_age == '1) ? rw_age : rw_age + 1'b1);
            rw_prev <= rw;
        end
    end

    // R3 / R5: read/write settled long enough before chip select falls
    p_rw_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (rw_age >= 16'(SU_CYC)));
    // R3 / R5: chip select low width for the access type
    p_cs_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (cs_low >= (rw ? 16'(RCS_CYC) : 16'(WCS_CYC))));
    // R3: read/write held after chip select rises
    p_rw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rw) |-> (cs_n && hi_age >= 16'(HOLD_CYC)));
    // R4: load strobe width, and only while chip select is high
    p_load_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_n) |-> (ld_low >= 16'(LOAD_CYC)));
    p_load_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |-> cs_n);
    // R8: reset width and select moves only as reset falls
    p_rst_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_rst_n) |-> (rst_low >= 16'(RST_CYC)));
    p_sel_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_mid) |-> $fell(dac_rst_n));
    // R11: bus driven only with the write level on read/write
    p_oe_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !rw);
    // R10: done is one cycle and never while busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dac_bus_seq dac_bus_seq_chk #(
    .SU_CYC   (SU_CYC),
    .HOLD_CYC (HOLD_CYC),
    .WCS_CYC  (WCS_CYC),
    .RCS_CYC  (RCS_CYC),
    .LOAD_CYC (LOAD_CYC),
    .RST_CYC  (RST_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (dac_cs_n),
    .rw        (dac_rw),
    .ld_n      (dac_ld_n),
    .dac_rst_n (dac_rst_n),
    .rst_mid   (dac_rst_mid),
    .oe        (dac_bus_oe),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_dac_bus_seq.sv
`timescale 1ns/1ps
module test_dac_bus_seq;
    localparam int P = 4;
    function automatic int cyc(int ns); int c; c = (ns + P - 1) / P; return (c < 1) ? 1 : c; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [15:0] req_data = '0;
    logic busy, done, cs_n, rw, ld_n, drst_n, rmid, oe;
    logic [15:0] rd_data, bus_out;
    logic [15:0] bus_in = 16'hBAD0;

    always #(P/2) clk = ~clk;

    dac_bus_seq #(.CLK_PERIOD_NS(P)) i_dac_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_data(req_data),
        .busy(busy), .done(done), .rd_data(rd_data), .dac_cs_n(cs_n), .dac_rw(rw), .dac_ld_n(ld_n),
        .dac_rst_n(drst_n), .dac_rst_mid(rmid), .dac_bus_out(bus_out), .dac_bus_oe(oe), .dac_bus_in(bus_in));

    typedef struct packed {
        logic busy, done, cs, rw, ld, rs, sel, oe;
        logic [15:0] data, rd;
    } ent_t;

    ent_t  q[$];
    string qt[$];
    int checks = 0, errors = 0;
    bit checking = 0;
    logic exp_sel = 1'b0;
    logic [15:0] exp_rd = '0, exp_in = '0, cur_data = '0;
    logic [15:0] m_in = '0, m_out = '0;

    // Converter model: input register, DAC register, bus read timing.
    always @(negedge cs_n) if (rw) begin
        bus_in = 16'hBAD0;
        #70;
        if (!cs_n) bus_in = m_in;
    end
    always @(posedge cs_n) begin
        if (!rw) m_in = bus_out;
        bus_in = 16'hBAD0;
    end
    always @(negedge clk) begin
        if (!drst_n) begin m_in = rmid ? 16'h7FFF : 16'hFFFF; m_out = m_in; end
        else if (!ld_n) m_out = m_in;
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
    endtask

    // Per-cycle comparison against the expected pin trace.
    always @(negedge clk) if (checking) begin
        ent_t e, a;
        string t;
        if (q.size() != 0) begin e = q.pop_front(); t = qt.pop_front(); end
        else begin
            e = '{busy:0, done:0, cs:1, rw:1, ld:1, rs:1, sel:exp_sel, oe:0, data:'0, rd:exp_rd};
            t = "R1/R2/R9 idle";
        end
        a = '{busy:busy, done:done, cs:cs_n, rw:rw, ld:ld_n, rs:drst_n, sel:rmid, oe:oe,
              data:(e.oe ? bus_out : 16'h0), rd:rd_data};
        if (!e.oe) e.data = 16'h0;
        chk(a == e, t, a, e);
    end

    task automatic add(int n, bit c, bit w, bit l, bit r, bit o, logic [15:0] rdv, string t);
        for (int i = 0; i < n; i++) begin
            q.push_back('{busy:1, done:0, cs:c, rw:w, ld:l, rs:r, sel:exp_sel, oe:o, data:cur_data, rd:rdv});
            qt.push_back(t);
        end
    endtask

    task automatic push_seq(logic [2:0] cmd, logic [15:0] d);
        case (cmd)
            3'd0, 3'd1: begin
                cur_data = d; exp_in = d;
                add(cyc(10), 1, 0, 1, 1, 1, exp_rd, "R3 setup");
                add(cyc(25), 0, 0, 1, 1, 1, exp_rd, "R3 strobe");
                add(cyc(10), 1, 0, 1, 1, 1, exp_rd, "R3 hold");
                if (cmd == 3'd1) add(cyc(20), 1, 1, 0, 1, 0, exp_rd, "R4 load after write");
            end
            3'd2: add(cyc(20), 1, 1, 0, 1, 0, exp_rd, "R4 load");
            3'd3: begin
                add(cyc(10), 1, 1, 1, 1, 0, exp_rd, "R5 setup");
                add(cyc(70), 0, 1, 1, 1, 0, exp_rd, "R5 strobe before sample");
                add(mx(cyc(90), cyc(70)) - cyc(70), 0, 1, 1, 1, 0, exp_in, "R6 strobe after sample");
                exp_rd = exp_in;
                add(mx(cyc(10), cyc(100)), 1, 1, 1, 1, 0, exp_rd, "R7 release wait");
            end
            default: begin
                exp_sel = (cmd == 3'd4);
                exp_in  = exp_sel ? 16'h7FFF : 16'hFFFF;
                add(cyc(30), 1, 1, 1, 0, 0, exp_rd, "R8 reset low");
                add(cyc(10), 1, 1, 1, 1, 0, exp_rd, "R8 select hold");
            end
        endcase
        q.push_back('{busy:0, done:1, cs:1, rw:1, ld:1, rs:1, sel:exp_sel, oe:0, data:cur_data, rd:exp_rd});
        qt.push_back("R10 done");
    endtask

    // Issue a command; optionally keep requesting another code while busy.
    task automatic issue(logic [2:0] cmd, logic [15:0] d, int noise = 0, logic [2:0] ncmd = 3'd3);
        @(posedge clk); #1 req_valid = 1; req_cmd = cmd; req_data = d;
        @(posedge clk); #1 req_valid = 0;
        push_seq(cmd, d);
        if (noise > 0) begin
            req_valid = 1; req_cmd = ncmd; req_data = ~d;
            repeat (noise) @(posedge clk);
            #1 req_valid = 0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 checking = 1;                  // R1 checked during reset too
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        repeat (3) @(posedge clk);
        issue(3'd0, 16'h1234);
        issue(3'd3, 16'h0);
        chk(rd_data == 16'h1234, "R6 read back of written word", rd_data, 16'h1234);
        issue(3'd1, 16'hA5A5);
        chk(m_out == 16'hA5A5, "R4 write then load updates DAC", m_out, 16'hA5A5);
        issue(3'd0, 16'h0F0F);
        chk(m_out == 16'hA5A5, "R3 write alone leaves DAC", m_out, 16'hA5A5);
        issue(3'd2, 16'h0);
        chk(m_out == 16'h0F0F, "R4 load only", m_out, 16'h0F0F);
        issue(3'd4, 16'h0);
        chk(m_out == 16'h7FFF, "R8 mid-scale reset", m_out, 16'h7FFF);
        issue(3'd3, 16'h0);
        chk(rd_data == 16'h7FFF, "R8 input register mid", rd_data, 16'h7FFF);
        issue(3'd5, 16'h0);
        chk(m_out == 16'hFFFF, "R8 min-scale reset", m_out, 16'hFFFF);
        issue(3'd3, 16'h0);
        chk(rd_data == 16'hFFFF, "R8 input register min", rd_data, 16'hFFFF);
        issue(3'd0, 16'hC3C3, 8, 3'd4);    // R9 request while busy ignored
        chk(m_out == 16'hFFFF && rmid == 1'b0, "R9 busy request dropped", {m_out, 15'd0, rmid}, {16'hFFFF, 16'd0});
        for (int c = 6; c < 8; c++) begin  // R2 unknown codes
            @(posedge clk); #1 req_valid = 1; req_cmd = 3'(c);
            repeat (3) @(posedge clk);
            #1 req_valid = 0;
        end
        repeat (2) @(posedge clk);
        issue(3'd3, 16'h0);
        chk(rd_data == 16'hC3C3, "R2 R9 state after ignored requests", rd_data, 16'hC3C3);
        issue(3'd1, 16'h0001);
        issue(3'd3, 16'h0);
        chk(rd_data == 16'h0001 && m_out == 16'h0001, "R6 R4 final", {rd_data, m_out}, {16'h0001, 16'h0001});
        repeat (4) @(posedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule